// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Arbiter

This block serves one processor of a multi-processor interrupt controller. Each cycle it looks at every interrupt source. A source joins arbitration only if its request line is high and its processor-select field names this processor. Among the sources that join, the block finds the highest priority, marks every source at that priority as a candidate, and picks the candidate with the lowest vector number. It then encodes that source's index as a 10-bit vector. A comparator raises the interrupt to the processor only when the winning priority is strictly above the processor's current priority.

Sources 0 to 31 are the software-settable interrupts and use vectors 0 to 31. Peripheral sources follow from vector 32 upward. The vector of a source is its index, which is unique. The number of sources and the width of the processor-select field are parameters. The outputs are registered.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A source takes part only when its bit of `req_i` is 1 and its field in `psel_i` (bits `i*SEL_W +: SEL_W`) equals parameter `PROC_ID`. All other sources have no effect on the outputs.
- R2: Priority is the 4-bit field `prio_i[i*4 +: 4]`, and a larger value means higher priority. The winner always has the highest priority among the participating sources.
- R3: When several participating sources share the highest priority, the one with the lowest index wins. The order in which they were asserted does not matter.
- R4: `vec_o` carries the winner's source index as a 10-bit value. Software sources 0..31 map to vectors 0..31, and peripheral sources map to 32 and up.
- R5: `irq_o` is 1 only when the winning priority is strictly greater than `cur_prio_i`. An equal or lower winning priority leaves `irq_o` at 0, but `vec_o` still names the winner.
- R6: A winner with priority 0 never sets `irq_o`, even when `cur_prio_i` is 0.
- R7: When no source takes part, `irq_o` is 0 and `vec_o` is 0.
- R8: `irq_o` and `vec_o` reflect the inputs sampled at the previous rising clock edge, which is one cycle of latency.
- R9: While `rst` is high at a clock edge, both outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_SRC | Request line per source |
| prio_i | input | N_SRC*4 | Packed 4-bit priority per source |
| psel_i | input | N_SRC*SEL_W | Packed processor-select field per source |
| cur_prio_i | input | 4 | Current priority of this processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 10 | Vector of the winning source |

## Verification
The hardest case to reach is a tie whose lower-indexed member arrives after a higher-indexed one, while sources routed to other processors carry even higher priority. A directed sequence asserts source 40 first and adds source 35 a cycle later at the same priority. It then adds a priority-15 source routed elsewhere and checks that the vector moves to 35 and ignores that source. A second sequence sets a software source against a peripheral source at equal priority. Hundreds of random cycles with mixed select fields and current priorities then exercise the strict comparison at its boundary.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
    localparam int PRIO_W = 4;
    localparam int VEC_W  = 10;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic irq;
        vec_t vec;
    } out_state_t;
endpackage

// File: rtl/ipa_prio_tree.sv
module ipa_prio_tree
    import ipa_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic [N_SRC-1:0]        part_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output prio_t                   max_o,
    output logic [N_SRC-1:0]        cand_o
);
    prio_t max_d;

    always_comb begin
        max_d = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (part_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > max_d))
                max_d = prio_i[i*PRIO_W +: PRIO_W];
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_cand
        assign cand_o[g] = part_i[g] && (prio_i[g*PRIO_W +: PRIO_W] == max_d);
    end

    assign max_o = max_d;
endmodule

// File: rtl/ipa_select.sv
module ipa_select #(
    parameter int N_SRC = 64,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_d = IDX_W'(i);
        end
    end

    assign any_o = |cand_i;
    assign idx_o = idx_d;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import ipa_pkg::*;
#(
    parameter int N_SRC   = 64,
    parameter int SEL_W   = 2,
    parameter int PROC_ID = 0,
    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SRC-1:0]         req_i,
    input  logic [N_SRC*PRIO_W-1:0]  prio_i,
    input  logic [N_SRC*SEL_W-1:0]   psel_i,
    input  logic [PRIO_W-1:0]        cur_prio_i,
    output logic                     irq_o,
    output logic [VEC_W-1:0]         vec_o
);
    logic [N_SRC-1:0] part;
    logic [N_SRC-1:0] cand;
    prio_t            max_prio;
    logic             any_cand;
    logic [IDX_W-1:0] win_idx;
    out_state_t       state_d, state_q;

    // participation mask: request high and routed to this processor
    for (genvar g = 0; g < N_SRC; g++) begin : g_part
        assign part[g] = req_i[g] && (psel_i[g*SEL_W +: SEL_W] == SEL_W'(PROC_ID));
    end

    ipa_prio_tree #(.N_SRC(N_SRC)) u_tree (
        .part_i (part),
        .prio_i (prio_i),
        .max_o  (max_prio),
        .cand_o (cand)
    );

    ipa_select #(.N_SRC(N_SRC)) u_sel (
        .cand_i (cand),
        .any_o  (any_cand),
        .idx_o  (win_idx)
    );

    // encoder and comparator
    always_comb begin
        state_d     = '0;
        state_d.irq = any_cand && (max_prio > cur_prio_i);
        state_d.vec = any_cand ? VEC_W'(win_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign irq_o = state_q.irq;
    assign vec_o = state_q.vec;

    // ---------------- assertions ----------------
    logic [N_SRC-1:0] below_win;
    prio_t            win_prio;
    always_comb begin
        below_win = (N_SRC'(1) << win_idx) - N_SRC'(1);
        win_prio  = prio_i[win_idx*PRIO_W +: PRIO_W];
    end

    p_win_participates_r1: assert property (@(posedge clk) disable iff (rst)
        any_cand |-> part[win_idx]);

    p_win_is_max_r2: assert property (@(posedge clk) disable iff (rst)
        any_cand |-> (win_prio == max_prio));

    p_no_lower_cand_r3: assert property (@(posedge clk) disable iff (rst)
        any_cand |-> ((cand & below_win) == '0));

    p_irq_strict_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(max_prio) > $past(cur_prio_i)));

    p_zero_never_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(max_prio) != '0));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(|part)) |-> (!irq_o && vec_o == '0));
endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 64;
    localparam int SELW  = 2;
    localparam int PROC  = 1;

    logic            clk = 0;
    logic            rst;
    logic [N-1:0]    req_i;
    logic [N*4-1:0]  prio_i;
    logic [N*SELW-1:0] psel_i;
    logic [3:0]      cur_prio_i;
    logic            irq_o;
    logic [9:0]      vec_o;

    logic [3:0]      pr [N];
    logic [SELW-1:0] ps [N];
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter #(.N_SRC(N), .SEL_W(SELW), .PROC_ID(PROC)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .prio_i(prio_i), .psel_i(psel_i),
        .cur_prio_i(cur_prio_i), .irq_o(irq_o), .vec_o(vec_o));

    task automatic pack_inputs();
        for (int i = 0; i < N; i++) begin
            prio_i[i*4 +: 4]       = pr[i];
            psel_i[i*SELW +: SELW] = ps[i];
        end
    endtask

    task automatic clear_all();
        req_i = '0;
        for (int i = 0; i < N; i++) begin
            pr[i] = '0;
            ps[i] = SELW'(PROC);
        end
        cur_prio_i = '0;
    endtask

    // behavioural reference: scan ascending, keep first strictly higher priority
    task automatic model(output logic e_irq, output int e_vec);
        int best = -1;
        int best_p = -1;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && ps[i] == SELW'(PROC) && int'(pr[i]) > best_p) begin
                best = i;
                best_p = int'(pr[i]);
            end
        end
        e_vec = (best < 0) ? 0 : best;
        e_irq = (best >= 0) && (best_p > int'(cur_prio_i)) && (best_p > 0);
    endtask

    // drive at falling edge, compare just after the next rising edge (R8)
    task automatic step(input string tag);
        logic e_irq;
        int   e_vec;
        @(negedge clk);
        pack_inputs();
        model(e_irq, e_vec);
        @(posedge clk);
        #1;
        checks++;
        if (irq_o !== e_irq || int'(vec_o) != e_vec) begin
            errors++;
            $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                     tag, irq_o, vec_o, e_irq, e_vec);
        end
    endtask

    task automatic expect_out(input string tag, input logic e_irq, input int e_vec);
        checks++;
        if (irq_o !== e_irq || int'(vec_o) != e_vec) begin
            errors++;
            $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                     tag, irq_o, vec_o, e_irq, e_vec);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_all();
        pack_inputs();
        rst = 1;
        // R9: reset clears outputs even with a live request
        req_i[5] = 1; pr[5] = 9;
        pack_inputs();
        repeat (2) @(posedge clk);
        #1;
        expect_out("R9 reset", 1'b0, 0);
        @(negedge clk);
        rst = 0;
        clear_all();

        // R7: nothing participating
        step("R7 idle");
        // R8: single request, one cycle latency visible on first sample
        req_i[45] = 1; pr[45] = 6; cur_prio_i = 2;
        step("R8 latency");
        // R2: higher priority wins regardless of index
        req_i[50] = 1; pr[50] = 11;
        step("R2 highest");
        // R1: higher priority routed to another processor is ignored
        req_i[60] = 1; pr[60] = 15; ps[60] = SELW'(PROC + 1);
        step("R1 other proc");
        req_i[50] = 0;
        step("R1 other proc only lower");
        // R3: arrival order: 40 first, then 35 at same priority
        clear_all();
        req_i[40] = 1; pr[40] = 5;
        step("R3 first arrival");
        req_i[35] = 1; pr[35] = 5;
        step("R3 later lower index");
        req_i[60] = 1; pr[60] = 15; ps[60] = SELW'(PROC + 2);
        step("R3 with foreign high");
        // R4: software source beats peripheral at equal priority
        req_i[3] = 1; pr[3] = 5;
        step("R4 software vector");
        clear_all();
        req_i[63] = 1; pr[63] = 7;
        step("R4 top peripheral vector");
        // R5: equal to current priority -> no irq, vector kept
        cur_prio_i = 7;
        step("R5 equal current");
        cur_prio_i = 6;
        step("R5 one above current");
        cur_prio_i = 15;
        step("R5 below current");
        // R6: priority 0 never preempts
        clear_all();
        req_i[10] = 1; pr[10] = 0;
        step("R6 zero priority");
        // R7: requests present but all routed elsewhere
        clear_all();
        req_i = '1;
        for (int i = 0; i < N; i++) begin ps[i] = SELW'(PROC + 1); pr[i] = 4'hF; end
        step("R7 all foreign");

        // random mix covering R1..R6
        for (int k = 0; k < 400; k++) begin
            int dens = (k % 4) + 1;
            for (int i = 0; i < N; i++) begin
                req_i[i] = ($urandom_range(0, 7) < dens);
                pr[i]    = 4'($urandom_range(0, 15));
                ps[i]    = SELW'($urandom_range(0, 3));
            end
            cur_prio_i = 4'($urandom_range(0, 15));
            step("R2 R3 R5 random");
        end

        // R9: reset mid-run
        @(negedge clk);
        rst = 1;
        @(posedge clk); #1;
        expect_out("R9 mid reset", 1'b0, 0);
        @(negedge clk);
        rst = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule